// File: doc/BRIEF.md
# Replay-Based Fault Diagnosis Sequencer

This controller decides what caused a detected symptom by replaying the suspect work and watching whether the symptom comes back. When a symptom is reported while it is idle, it first asks the execution fabric to restore the suspect core to its last checkpoint. It then asks for a replay on that same core. A clean replay means the event was transient or a non-deterministic software effect. The controller reports that result and pulses a resume request.

If the symptom comes back on the suspect core, the controller asks for the checkpoint to be loaded on a known-good core and replayed there. If the symptom appears there too, the cause is a deterministic software bug or a false positive from a software invariant, and the result goes to software. If the good core runs clean, the suspect core has a permanent hardware fault. The controller reports it and pulses a start request for trace-based diagnosis.

Each request is a level that stays high until the fabric returns a one-cycle done, which carries a symptom flag. A replay that runs past a cycle limit without finishing counts as a symptom. The result stays on the outputs until software acknowledges it. Symptoms that arrive while a diagnosis is in progress are dropped.

Top module: `replay_diag_seq`

## Requirements
- R1: After synchronous reset, all four request outputs, `verdict_valid`, `resume_pulse` and `diag_start` are low.
- R2: A `symptom_in` pulse while idle raises `req_rollback_local` on the next cycle, and it stays high until a cycle with `step_done` high.
- R3: A done for the local rollback lowers `req_rollback_local` and raises `req_replay_local` on the next cycle.
- R4: A local replay that finishes with `step_symptom` low gives `verdict_valid`=1 and `verdict_code`=2'b01 (transient) on the next cycle, together with a one-cycle `resume_pulse`.
- R5: A local replay that ends with a symptom raises `req_load_remote` on the next cycle. Its done then raises `req_replay_remote` on the next cycle.
- R6: A remote replay that ends with a symptom gives `verdict_code`=2'b10 (software bug or false positive) with `verdict_valid`=1.
- R7: A remote replay that finishes with `step_symptom` low gives `verdict_code`=2'b11 (permanent fault) with `verdict_valid`=1, together with a one-cycle `diag_start`.
- R8: A replay request that sees no done for `TMO_CYCLES` cycles is dropped after exactly `TMO_CYCLES` cycles high, and the replay is treated as having shown the symptom.
- R9: `verdict_valid` and `verdict_code` hold while `verdict_ack` is low. One cycle after `verdict_ack`, `verdict_valid` is low and the controller is idle.
- R10: `symptom_in` while a diagnosis or a held result is active has no effect. `step_done` while no request is active has no effect.
- R11: At most one request output is high in any cycle, and none is high while `verdict_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| symptom_in | input | 1 | Symptom detected, starts a diagnosis when idle |
| step_done | input | 1 | One-cycle completion of the current request |
| step_symptom | input | 1 | With step_done: the replay showed the symptom |
| verdict_ack | input | 1 | Software acknowledges the held result |
| req_rollback_local | output | 1 | Restore the suspect core to its checkpoint |
| req_replay_local | output | 1 | Replay on the suspect core |
| req_load_remote | output | 1 | Load the checkpoint on a fault-free core |
| req_replay_remote | output | 1 | Replay on the fault-free core |
| verdict_valid | output | 1 | A classification is held |
| verdict_code | output | 2 | 01 transient, 10 software, 11 permanent |
| resume_pulse | output | 1 | One cycle: resume normal execution |
| diag_start | output | 1 | One cycle: start trace-based diagnosis |

## Verification
A wrong sequencer state shows up at the request outputs on the cycle after the offending done. The wrong request rises, two rise at once, or none does. A wrong replay outcome shows up as a wrong `verdict_code` on the cycle after the replay finishes, and a missing or extra `resume_pulse` or `diag_start` appears in that same cycle. A fault in the replay timer shows up as a replay request that stays high for more or fewer than `TMO_CYCLES` cycles.

// File: rtl/rds_pkg.sv
package rds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RB_LOCAL  = 3'd1,
    ST_RP_LOCAL  = 3'd2,
    ST_LD_REMOTE = 3'd3,
    ST_RP_REMOTE = 3'd4,
    ST_VERDICT   = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    V_NONE      = 2'b00,
    V_TRANSIENT = 2'b01,
    V_SOFTWARE  = 2'b10,
    V_PERMANENT = 2'b11
  } verdict_e;
endpackage

// File: rtl/rds_step_timer.sv
module rds_step_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/rds_verdict_hold.sv
module rds_verdict_hold
  import rds_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  verdict_e code_in,
  input  logic     clear,
  output logic     valid,
  output verdict_e code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      code  <= V_NONE;
    end else if (load) begin
      valid <= 1'b1;
      code  <= code_in;
    end else if (clear) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/replay_diag_seq.sv
module replay_diag_seq
  import rds_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       symptom_in,
  input  logic       step_done,
  input  logic       step_symptom,
  input  logic       verdict_ack,
  output logic       req_rollback_local,
  output logic       req_replay_local,
  output logic       req_load_remote,
  output logic       req_replay_remote,
  output logic       verdict_valid,
  output logic [1:0] verdict_code,
  output logic       resume_pulse,
  output logic       diag_start
);
  seq_state_e state, state_n;
  logic       in_replay, tmo_hit, replay_end, replay_bad;
  logic       v_load, v_clear;
  verdict_e   v_code_n, v_code_q;

  assign in_replay  = (state == ST_RP_LOCAL) || (state == ST_RP_REMOTE);
  assign replay_end = step_done || tmo_hit;
  assign replay_bad = step_done ? step_symptom : 1'b1;
  assign v_clear    = (state == ST_VERDICT) && verdict_ack;

  rds_step_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (in_replay),
    .expired (tmo_hit)
  );

  always_comb begin
    state_n  = state;
    v_load   = 1'b0;
    v_code_n = V_NONE;
    unique case (state)
      ST_IDLE:      if (symptom_in) state_n = ST_RB_LOCAL;
      ST_RB_LOCAL:  if (step_done) state_n = ST_RP_LOCAL;
      ST_RP_LOCAL:
        if (replay_end) begin
          if (replay_bad) state_n = ST_LD_REMOTE;
          else begin
            state_n  = ST_VERDICT;
            v_load   = 1'b1;
            v_code_n = V_TRANSIENT;
          end
        end
      ST_LD_REMOTE: if (step_done) state_n = ST_RP_REMOTE;
      ST_RP_REMOTE:
        if (replay_end) begin
          state_n  = ST_VERDICT;
          v_load   = 1'b1;
          v_code_n = replay_bad ? V_SOFTWARE : V_PERMANENT;
        end
      ST_VERDICT:   if (verdict_ack) state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state              <= ST_IDLE;
      req_rollback_local <= 1'b0;
      req_replay_local   <= 1'b0;
      req_load_remote    <= 1'b0;
      req_replay_remote  <= 1'b0;
      resume_pulse       <= 1'b0;
      diag_start         <= 1'b0;
    end else begin
      state              <= state_n;
      req_rollback_local <= (state_n == ST_RB_LOCAL);
      req_replay_local   <= (state_n == ST_RP_LOCAL);
      req_load_remote    <= (state_n == ST_LD_REMOTE);
      req_replay_remote  <= (state_n == ST_RP_REMOTE);
      resume_pulse       <= v_load && (v_code_n == V_TRANSIENT);
      diag_start         <= v_load && (v_code_n == V_PERMANENT);
    end
  end

  rds_verdict_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (v_load),
    .code_in (v_code_n),
    .clear   (v_clear),
    .valid   (verdict_valid),
    .code    (v_code_q)
  );

  assign verdict_code = v_code_q;
endmodule

// File: rtl/rds_checker.sv
module rds_checker #(
  parameter int TMO_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       symptom_in,
  input logic       step_done,
  input logic       step_symptom,
  input logic       verdict_ack,
  input logic       req_rollback_local,
  input logic       req_replay_local,
  input logic       req_load_remote,
  input logic       req_replay_remote,
  input logic       verdict_valid,
  input logic [1:0] verdict_code,
  input logic       resume_pulse,
  input logic       diag_start
);
  localparam int CW = $clog2(TMO_CYCLES + 2);
  logic [CW-1:0] rp_run;

  always_ff @(posedge clk) begin
    if (rst || !req_replay_local) rp_run <= '0;
    else rp_run <= rp_run + 1'b1;
  end

  p_rb_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(req_rollback_local) |-> $past(symptom_in));
  p_rb_hold_r2: assert property (@(posedge clk) disable iff (rst)
    req_rollback_local && !step_done |=> req_rollback_local);
  p_rb_next_r3: assert property (@(posedge clk) disable iff (rst)
    req_rollback_local && step_done |=> req_replay_local && !req_rollback_local);
  p_resume_r4: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |-> verdict_valid && verdict_code == 2'b01);
  p_sw_r6: assert property (@(posedge clk) disable iff (rst)
    req_replay_remote && step_done && step_symptom |=> verdict_valid && verdict_code == 2'b10);
  p_diag_r7: assert property (@(posedge clk) disable iff (rst)
    diag_start |-> verdict_valid && verdict_code == 2'b11);
  p_tmo_len_r8: assert property (@(posedge clk) disable iff (rst)
    int'(rp_run) <= TMO_CYCLES);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    verdict_valid && !verdict_ack |=> verdict_valid && $stable(verdict_code));
  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    verdict_valid && symptom_in |=> !req_rollback_local);
  p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_rollback_local, req_replay_local, req_load_remote, req_replay_remote, verdict_valid}));
endmodule

bind replay_diag_seq rds_checker #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .symptom_in         (symptom_in),
  .step_done          (step_done),
  .step_symptom       (step_symptom),
  .verdict_ack        (verdict_ack),
  .req_rollback_local (req_rollback_local),
  .req_replay_local   (req_replay_local),
  .req_load_remote    (req_load_remote),
  .req_replay_remote  (req_replay_remote),
  .verdict_valid      (verdict_valid),
  .verdict_code       (verdict_code),
  .resume_pulse       (resume_pulse),
  .diag_start         (diag_start)
);

// File: tb/replay_diag_seq_bench.sv
module replay_diag_seq_bench;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst, symptom_in, step_done, step_symptom, verdict_ack;
  logic req_rollback_local, req_replay_local, req_load_remote, req_replay_remote;
  logic verdict_valid, resume_pulse, diag_start;
  logic [1:0] verdict_code;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  replay_diag_seq #(.TMO_CYCLES(TMO)) u_replay_diag_seq (.*);

  // {local symptom, local timeout, remote symptom, remote timeout, expected code}
  localparam logic [5:0] VEC [6] = '{
    {4'b0000, 2'b01},
    {4'b1010, 2'b10},
    {4'b1000, 2'b11},
    {4'b0100, 2'b11},
    {4'b1001, 2'b10},
    {4'b0101, 2'b10}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int reqs();
    return int'(req_rollback_local) + int'(req_replay_local) + int'(req_load_remote) + int'(req_replay_remote);
  endfunction

  task automatic pulse_done(input logic sym);
    step_done = 1'b1; step_symptom = sym;
    @(negedge clk);
    step_done = 1'b0; step_symptom = 1'b0;
  endtask

  // local/remote replay: tmo -> count high cycles, else done with symptom flag
  task automatic do_replay(input bit tmo, input bit sym, input bit local_side);
    if (tmo) begin
      int n = 0;
      while ((local_side ? req_replay_local : req_replay_remote) && n < TMO + 5) begin
        n++;
        @(negedge clk);
      end
      check("R8 replay timeout length", n, TMO);
    end else begin
      repeat (2) @(negedge clk);
      pulse_done(sym);
    end
  endtask

  task automatic run_seq(input logic [5:0] v, input bit inject_busy);
    symptom_in = 1'b1;
    @(negedge clk);
    symptom_in = 1'b0;
    check("R2 rollback request", req_rollback_local, 1);
    if (inject_busy) begin
      symptom_in = 1'b1;
      @(negedge clk);
      symptom_in = 1'b0;
      check("R10 symptom while busy", reqs() == 1 && req_rollback_local, 1);
    end
    repeat (2) @(negedge clk);
    check("R2 rollback held", req_rollback_local, 1);
    pulse_done(1'b0);
    check("R3 local replay request", req_replay_local && !req_rollback_local, 1);
    check("R11 one request", reqs(), 1);
    do_replay(v[4], v[5], 1'b1);
    if (!(v[5] | v[4])) begin
      check("R4 transient valid", verdict_valid, 1);
      check("R4 transient code", verdict_code, 1);
      check("R4 resume pulse", resume_pulse, 1);
    end else begin
      check("R5 remote load request", req_load_remote && !req_replay_local, 1);
      repeat (1) @(negedge clk);
      pulse_done(1'b0);
      check("R5 remote replay request", req_replay_remote && !req_load_remote, 1);
      do_replay(v[2], v[3], 1'b0);
      check("R6/R7 verdict valid", verdict_valid, 1);
      check(v[1:0] == 2'b11 ? "R7 permanent code" : "R6 software code", verdict_code, v[1:0]);
      check("R7 diag start", diag_start, v[1:0] == 2'b11);
      check("R4 no resume", resume_pulse, 0);
    end
    check("R11 no request with verdict", reqs(), 0);
    @(negedge clk);
    check("R4/R7 pulses one cycle", resume_pulse | diag_start, 0);
  endtask

  task automatic ack_verdict();
    verdict_ack = 1'b1;
    @(negedge clk);
    verdict_ack = 1'b0;
    check("R9 valid clears on ack", verdict_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; symptom_in = 0; step_done = 0; step_symptom = 0; verdict_ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset requests", reqs(), 0);
    check("R1 reset valid", verdict_valid, 0);
    check("R1 reset pulses", resume_pulse | diag_start, 0);

    for (int i = 0; i < 6; i++) begin
      run_seq(VEC[i], 1'b0);
      ack_verdict();
    end

    // R10: done with nothing requested
    pulse_done(1'b1);
    @(negedge clk);
    check("R10 stray done", reqs() + int'(verdict_valid), 0);

    // R9 hold + R10 symptom during held verdict
    run_seq({4'b1000, 2'b11}, 1'b1);
    repeat (4) @(negedge clk);
    check("R9 verdict held valid", verdict_valid, 1);
    check("R9 verdict held code", verdict_code, 3);
    symptom_in = 1'b1;
    @(negedge clk);
    symptom_in = 1'b0;
    check("R10 symptom during verdict", reqs(), 0);
    check("R9 still held", verdict_valid, 1);
    ack_verdict();
    @(negedge clk);
    check("R10 no late start", reqs(), 0);

    // back-to-back: new diagnosis right after ack
    run_seq({4'b0000, 2'b01}, 1'b0);
    ack_verdict();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule